// File: doc/BRIEF.md
# Multi-counter event performance monitor

This block counts hardware events for software profiling. A small set of counters (four by default) sits behind a simple 64-bit register bus. Each counter is told which event category and which event code to follow. Event sources present one pulse line per category together with an event code and a packed attribute tag. A counter advances by one on every cycle in which its category pulses with a matching code and the attribute tag passes all of that counter's filters. Five filter types can be programmed per counter: work queue, traffic class, page size, transfer size and engine.

Counters are `CTR_W` bits wide and wrap to zero. A wrap records a sticky flag in an overflow status word, which software clears by writing ones. Each counter can route its flag to a single interrupt line. One global register freezes all counters without losing their values. A command register clears the whole configuration or zeroes all counter values. A read-only capability word tells software the geometry and features of the unit.

Top module: `evt_perf_monitor`

## Requirements
- R1: Reading byte offset 0x00 returns the capability word: bits [7:0] give the counter count, [15:8] the counter width, bit 16 = 1 (overflow interrupt supported), bit 17 = 1 (freeze supported), [23:20] the category count, [47:32] a bitmap with one set bit per implemented category, [52:48] = 5'b11111 (all five filter types) and bit 53 = 0 (no per-counter capabilities). All other bits are zero.
- R2: Counter i has its configuration register at offset 0x40·(i+1). Bit 0 enables counting, bit 1 enables the overflow interrupt, bits [11:8] select the category and bits [16+:CODE_W] select the event code. An enabled counter that is not frozen adds exactly one on each cycle in which its category's pulse is high, that category's code equals the programmed code, and the filters pass. Otherwise it holds its value.
- R3: A counter wraps modulo 2^CTR_W. The clock edge that takes it from all ones to zero also sets bit i of the overflow status register at offset 0x10.
- R4: Writing the overflow status register clears each bit written as 1 and leaves each bit written as 0. If a wrap happens on the same edge, that wrap's bit stays set.
- R5: Writing 1 to bit 0 of the freeze register at offset 0x18 stops every counter, and writing 0 restarts them. Values are held while frozen, and the register reads back its state in bit 0.
- R6: Writing the command register at offset 0x08 with bit 0 set clears all configuration and filter registers, the overflow status and the freeze state, and leaves counter values untouched. Writing it with bit 1 set zeroes every counter value and leaves configuration untouched. The register reads as zero.
- R7: The interrupt output is high exactly when some counter has both its overflow status bit and its interrupt enable set.
- R8: The filter registers of counter i are at offset 0x40·(i+1) + 0x10 (work queue, 32 bits), +0x18 (traffic class, 8 bits), +0x20 (page size, 4 bits), +0x28 (transfer size, 8 bits) and +0x30 (engine, 8 bits). Each category's 16-bit attribute tag holds, from bit 15 down, the work queue index [15:11], traffic class [10:8], page size [7:6], transfer size [5:3] and engine [2:0]. A filter holding zero always passes. A nonzero filter passes only if the bit selected by the attribute's index is set.
- R9: The counter value at offset 0x40·(i+1) + 0x08 reads as 64 bits, zero-extended above CTR_W. A write loads bits [CTR_W-1:0] whatever the enable and freeze states, and it wins over an event on the same edge.
- R10: A read request (bus_req high, bus_wr low) returns its data on bus_rdata with bus_rvalid high in the next cycle. A write takes effect at the edge where it is presented. Reads of unused offsets or of addresses with nonzero low three bits return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| evt_pulse | input | N_CAT | One event pulse per category |
| evt_code | input | N_CAT*CODE_W | Event code per category |
| evt_attr | input | N_CAT*16 | Attribute tag per category |
| irq | output | 1 | Overflow interrupt |

## Verification
An event presented in one cycle is counted at the next rising edge. The overflow flag and the interrupt change at that same edge, so both can be observed half a cycle later. Register writes land at the edge where they are presented. Read data appears one cycle after the request and reflects the state just before that edge. The bench drives every input on a falling edge and samples on the following falling edge, so each check falls exactly one edge after its cause. Before any value is read back, the event stream is idle or the counters are frozen, so the expected counts are exact.

// File: rtl/epm_pkg.sv
// Package for the event performance monitor: register slot indices,
// configuration bit positions, filter widths and the attribute tag layout.
package epm_pkg;

    // Global block slots (64-bit beats at byte offset slot*8)
    localparam logic [2:0] OFS_CAP = 3'd0;
    localparam logic [2:0] OFS_CMD = 3'd1;
    localparam logic [2:0] OFS_OVF = 3'd2;
    localparam logic [2:0] OFS_FRZ = 3'd3;

    // Per-counter block slots; block i+1 belongs to counter i
    localparam logic [2:0] SLOT_CFG  = 3'd0;
    localparam logic [2:0] SLOT_DATA = 3'd1;
    localparam int         SLOT_FLT0 = 2;
    localparam int         NUM_FLT   = 5;
    localparam int         BLK_SHIFT = 6;

    // Configuration word fields
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_IRQ_BIT  = 1;
    localparam int CFG_CAT_LSB  = 8;
    localparam int CAT_FW       = 4;
    localparam int CFG_CODE_LSB = 16;

    // Command word bits
    localparam int CMD_CFG_BIT = 0;
    localparam int CMD_CNT_BIT = 1;

    // Filter widths, index order wq, tc, pg, xf, en
    localparam int FW_WQ = 32;
    localparam int FW_TC = 8;
    localparam int FW_PG = 4;
    localparam int FW_XF = 8;
    localparam int FW_EN = 8;

    // Attribute tag carried with each category's event pulse
    typedef struct packed {
        logic [4:0] wq;
        logic [2:0] tc;
        logic [1:0] pg;
        logic [2:0] xf;
        logic [2:0] en;
    } evt_attr_t;

    localparam int ATTR_W = $bits(evt_attr_t);

endpackage

// File: rtl/epm_filter_gate.sv
// Filter gate: decides whether one attribute tag passes the five
// per-counter mask filters. Assumes a zero mask means "filter off";
// a nonzero mask passes only if the bit indexed by the attribute is set.
module epm_filter_gate
    import epm_pkg::*;
(
    input  evt_attr_t          attr,
    input  logic [FW_WQ-1:0]   f_wq,
    input  logic [FW_TC-1:0]   f_tc,
    input  logic [FW_PG-1:0]   f_pg,
    input  logic [FW_XF-1:0]   f_xf,
    input  logic [FW_EN-1:0]   f_en,
    output logic               pass
);

    logic ok_wq, ok_tc, ok_pg, ok_xf, ok_en;

    // Each filter is either disabled or tests one indexed bit
    always_comb begin
        ok_wq = (f_wq == '0) || f_wq[attr.wq];
        ok_tc = (f_tc == '0) || f_tc[attr.tc];
        ok_pg = (f_pg == '0) || f_pg[attr.pg];
        ok_xf = (f_xf == '0) || f_xf[attr.xf];
        ok_en = (f_en == '0) || f_en[attr.en];
        pass  = ok_wq && ok_tc && ok_pg && ok_xf && ok_en;
    end

endmodule

// File: rtl/epm_ctr_slice.sv
// One counter slice: holds the configuration, the five filters and the
// counter value, selects its category's event, and reports a wrap.
// Assumes the top decodes the bus into per-register write strobes and
// that config reset and counter reset arrive as single-cycle pulses.
module epm_ctr_slice
    import epm_pkg::*;
#(
    parameter int N_CAT  = 4,
    parameter int CTR_W  = 48,
    parameter int CODE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_clr,
    input  logic                      cnt_clr,
    input  logic                      wr_cfg,
    input  logic                      wr_data,
    input  logic [NUM_FLT-1:0]        wr_flt,
    input  logic [63:0]               wdata,
    input  logic                      frozen,
    input  logic [N_CAT-1:0]          evt_pulse,
    input  logic [N_CAT*CODE_W-1:0]   evt_code,
    input  logic [N_CAT*ATTR_W-1:0]   evt_attr,
    input  logic [2:0]                rd_slot,
    output logic [63:0]               rd_word,
    output logic                      irq_en,
    output logic                      wrap,
    output logic [CTR_W-1:0]          cnt_val
);

    logic              en_q, irq_q;
    logic [CAT_FW-1:0] cat_q;
    logic [CODE_W-1:0] code_q;
    logic [FW_WQ-1:0]  f_wq;
    logic [FW_TC-1:0]  f_tc;
    logic [FW_PG-1:0]  f_pg;
    logic [FW_XF-1:0]  f_xf;
    logic [FW_EN-1:0]  f_en;
    logic [CTR_W-1:0]  cnt_q;

    logic              sel_pulse;
    logic [CODE_W-1:0] sel_code;
    evt_attr_t         sel_attr;
    logic              flt_pass;
    logic              inc;
    logic              unused_wbits;

    assign unused_wbits = ^wdata;

    // Route the selected category's pulse, code and tag to this slice
    always_comb begin
        sel_pulse = 1'b0;
        sel_code  = '0;
        sel_attr  = '0;
        for (int c = 0; c < N_CAT; c++) begin
            if (cat_q == CAT_FW'(c)) begin
                sel_pulse = evt_pulse[c];
                sel_code  = evt_code[c*CODE_W +: CODE_W];
                sel_attr  = evt_attr_t'(evt_attr[c*ATTR_W +: ATTR_W]);
            end
        end
    end

    epm_filter_gate flt_i (
        .attr (sel_attr),
        .f_wq (f_wq),
        .f_tc (f_tc),
        .f_pg (f_pg),
        .f_xf (f_xf),
        .f_en (f_en),
        .pass (flt_pass)
    );

    // Count condition and wrap detection (a load or clear suppresses both)
    always_comb begin
        inc  = en_q && !frozen && sel_pulse && (sel_code == code_q) && flt_pass;
        wrap = inc && (&cnt_q) && !wr_data && !cnt_clr;
    end

    // Configuration register: cleared by reset or config-reset command
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_clr) begin
            en_q   <= 1'b0;
            irq_q  <= 1'b0;
            cat_q  <= '0;
            code_q <= '0;
        end else if (wr_cfg) begin
            en_q   <= wdata[CFG_EN_BIT];
            irq_q  <= wdata[CFG_IRQ_BIT];
            cat_q  <= wdata[CFG_CAT_LSB +: CAT_FW];
            code_q <= wdata[CFG_CODE_LSB +: CODE_W];
        end
    end

    // Filter registers: each written on its own strobe
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_clr) begin
            f_wq <= '0;
            f_tc <= '0;
            f_pg <= '0;
            f_xf <= '0;
            f_en <= '0;
        end else begin
            if (wr_flt[0]) f_wq <= wdata[FW_WQ-1:0];
            if (wr_flt[1]) f_tc <= wdata[FW_TC-1:0];
            if (wr_flt[2]) f_pg <= wdata[FW_PG-1:0];
            if (wr_flt[3]) f_xf <= wdata[FW_XF-1:0];
            if (wr_flt[4]) f_en <= wdata[FW_EN-1:0];
        end
    end

    // Counter value: clear, then bus load, then event increment
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) begin
            cnt_q <= '0;
        end else if (wr_data) begin
            cnt_q <= wdata[CTR_W-1:0];
        end else if (inc) begin
            cnt_q <= cnt_q + CTR_W'(1);
        end
    end

    // Read-back word for the slot the top addresses
    always_comb begin
        rd_word = '0;
        case (rd_slot)
            SLOT_CFG: begin
                rd_word[CFG_EN_BIT]                 = en_q;
                rd_word[CFG_IRQ_BIT]                = irq_q;
                rd_word[CFG_CAT_LSB +: CAT_FW]      = cat_q;
                rd_word[CFG_CODE_LSB +: CODE_W]     = code_q;
            end
            SLOT_DATA:             rd_word = 64'(cnt_q);
            3'(SLOT_FLT0 + 0):     rd_word = 64'(f_wq);
            3'(SLOT_FLT0 + 1):     rd_word = 64'(f_tc);
            3'(SLOT_FLT0 + 2):     rd_word = 64'(f_pg);
            3'(SLOT_FLT0 + 3):     rd_word = 64'(f_xf);
            3'(SLOT_FLT0 + 4):     rd_word = 64'(f_en);
            default:               rd_word = '0;
        endcase
    end

    assign irq_en  = irq_q;
    assign cnt_val = cnt_q;

endmodule

// File: rtl/evt_perf_monitor.sv
// Event performance monitor top: decodes the register bus, holds the
// global freeze, overflow status and command logic, builds the capability
// word and the interrupt, and instantiates one slice per counter.
// Assumes 64-bit aligned accesses; misaligned reads return zero and
// misaligned writes are dropped.
module evt_perf_monitor
    import epm_pkg::*;
#(
    parameter int N_CTR  = 4,
    parameter int CTR_W  = 48,
    parameter int N_CAT  = 4,
    parameter int CODE_W = 8,
    parameter int ADDR_W = $clog2((N_CTR + 1) * 64)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [63:0]               bus_wdata,
    output logic [63:0]               bus_rdata,
    output logic                      bus_rvalid,
    input  logic [N_CAT-1:0]          evt_pulse,
    input  logic [N_CAT*CODE_W-1:0]   evt_code,
    input  logic [N_CAT*ATTR_W-1:0]   evt_attr,
    output logic                      irq
);

    localparam int          BLK_W   = ADDR_W - BLK_SHIFT;
    localparam logic [15:0] CAT_MAP = 16'((32'd1 << N_CAT) - 1);

    // Capability word assembled from the parameters
    localparam logic [63:0] CAP_WORD =
          64'(8'(N_CTR))
        | (64'(8'(CTR_W)) << 8)
        | (64'd1 << 16)
        | (64'd1 << 17)
        | (64'(4'(N_CAT)) << 20)
        | (64'(CAT_MAP) << 32)
        | (64'h1F << 48);

    logic [BLK_W-1:0]         blk;
    logic [2:0]               slot;
    logic                     addr_ok;
    logic                     wr_en;
    logic                     glob_wr;
    logic                     cmd_wr, cfg_clr, cnt_clr, ovf_wr, frz_wr;
    logic                     frz_q;
    logic [N_CTR-1:0]         ovf_q;
    logic [N_CTR-1:0]         wrap_vec;
    logic [N_CTR-1:0]         irq_en_vec;
    logic [N_CTR*CTR_W-1:0]   cnt_flat;
    logic [63:0]              slice_rd [N_CTR];
    logic [63:0]              rd_next;

    // Address split into block, slot and alignment check
    always_comb begin
        blk     = bus_addr[ADDR_W-1:BLK_SHIFT];
        slot    = bus_addr[BLK_SHIFT-1:3];
        addr_ok = (bus_addr[2:0] == 3'd0);
        wr_en   = bus_req && bus_wr && addr_ok;
        glob_wr = wr_en && (blk == '0);
        cmd_wr  = glob_wr && (slot == OFS_CMD);
        cfg_clr = cmd_wr && bus_wdata[CMD_CFG_BIT];
        cnt_clr = cmd_wr && bus_wdata[CMD_CNT_BIT];
        ovf_wr  = glob_wr && (slot == OFS_OVF);
        frz_wr  = glob_wr && (slot == OFS_FRZ);
    end

    // Global freeze state
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_clr) begin
            frz_q <= 1'b0;
        end else if (frz_wr) begin
            frz_q <= bus_wdata[0];
        end
    end

    // Overflow status: write-1-to-clear, a wrap on the same edge wins
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_clr) begin
            ovf_q <= '0;
        end else begin
            ovf_q <= (ovf_q & ~(ovf_wr ? bus_wdata[N_CTR-1:0] : '0)) | wrap_vec;
        end
    end

    // One slice per counter with its own write strobes
    for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
        logic               hit;
        logic [NUM_FLT-1:0] flt_we;

        assign hit = wr_en && (blk == BLK_W'(i + 1));

        // Filter write strobes, one per filter slot
        always_comb begin
            for (int k = 0; k < NUM_FLT; k++) begin
                flt_we[k] = hit && (slot == 3'(SLOT_FLT0 + k));
            end
        end

        epm_ctr_slice #(
            .N_CAT  (N_CAT),
            .CTR_W  (CTR_W),
            .CODE_W (CODE_W)
        ) slice_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_clr   (cfg_clr),
            .cnt_clr   (cnt_clr),
            .wr_cfg    (hit && (slot == SLOT_CFG)),
            .wr_data   (hit && (slot == SLOT_DATA)),
            .wr_flt    (flt_we),
            .wdata     (bus_wdata),
            .frozen    (frz_q),
            .evt_pulse (evt_pulse),
            .evt_code  (evt_code),
            .evt_attr  (evt_attr),
            .rd_slot   (slot),
            .rd_word   (slice_rd[i]),
            .irq_en    (irq_en_vec[i]),
            .wrap      (wrap_vec[i]),
            .cnt_val   (cnt_flat[i*CTR_W +: CTR_W])
        );
    end

    // Read multiplexer over the global block and the counter blocks
    always_comb begin
        rd_next = '0;
        if (addr_ok) begin
            if (blk == '0) begin
                case (slot)
                    OFS_CAP: rd_next = CAP_WORD;
                    OFS_OVF: rd_next = 64'(ovf_q);
                    OFS_FRZ: rd_next = 64'(frz_q);
                    default: rd_next = '0;
                endcase
            end else begin
                for (int i = 0; i < N_CTR; i++) begin
                    if (blk == BLK_W'(i + 1)) rd_next = slice_rd[i];
                end
            end
        end
    end

    // Registered read response, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_req && !bus_wr;
            bus_rdata  <= (bus_req && !bus_wr) ? rd_next : '0;
        end
    end

    // Interrupt: any flagged counter with its interrupt enabled
    assign irq = |(ovf_q & irq_en_vec);

endmodule

// File: rtl/epm_checker.sv
// Assertion checker for the event performance monitor, bound to the top.
// Observes the overflow status, wraps, freeze state and bus handshake.
module epm_checker #(
    parameter int N_CTR = 4,
    parameter int CTR_W = 48
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_req,
    input logic                    bus_wr,
    input logic [63:0]             bus_wdata,
    input logic                    bus_rvalid,
    input logic                    irq,
    input logic                    ovf_wr,
    input logic                    cfg_clr,
    input logic                    frz_q,
    input logic [N_CTR-1:0]        ovf_q,
    input logic [N_CTR-1:0]        wrap_vec,
    input logic [N_CTR*CTR_W-1:0]  cnt_flat
);

    // R3: a wrap leaves its status bit set after the edge
    a_r3_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((wrap_vec != '0) && !cfg_clr) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

    // R4: bits written as 1 clear unless a wrap hit them on the same edge
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_wr |=> ((ovf_q & $past(bus_wdata[N_CTR-1:0]) & ~$past(wrap_vec)) == '0));

    // R4: bits written as 0 keep their value
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_wr && !cfg_clr) |=>
            ((ovf_q & $past(ovf_q & ~bus_wdata[N_CTR-1:0])) == $past(ovf_q & ~bus_wdata[N_CTR-1:0])));

    // R5: frozen counters hold when no bus write touches them
    a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_q && !(bus_req && bus_wr)) |=> $stable(cnt_flat));

    // R6: config reset leaves no status and no freeze
    a_r6_cfg_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr |=> ((ovf_q == '0) && !frz_q));

    // R7: the interrupt needs a pending status bit
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_q != '0));

    // R10: read data valid exactly one cycle after a read request
    a_r10_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr) |=> bus_rvalid);

    a_r10_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_wr) |=> !bus_rvalid);

endmodule

bind evt_perf_monitor epm_checker #(
    .N_CTR (N_CTR),
    .CTR_W (CTR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .irq        (irq),
    .ovf_wr     (ovf_wr),
    .cfg_clr    (cfg_clr),
    .frz_q      (frz_q),
    .ovf_q      (ovf_q),
    .wrap_vec   (wrap_vec),
    .cnt_flat   (cnt_flat)
);

// File: tb/evt_perf_monitor_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the event performance monitor: one task per scenario.
module evt_perf_monitor_tb_top;

    localparam int N_CTR  = 4;
    localparam int CTR_W  = 48;
    localparam int N_CAT  = 4;
    localparam int CODE_W = 8;
    localparam int ADDR_W = 9;
    localparam logic [63:0] MAXV = (64'd1 << CTR_W) - 1;

    localparam logic [8:0] A_CAP = 9'h000;
    localparam logic [8:0] A_CMD = 9'h008;
    localparam logic [8:0] A_OVF = 9'h010;
    localparam logic [8:0] A_FRZ = 9'h018;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    bus_req = 1'b0;
    logic                    bus_wr = 1'b0;
    logic [ADDR_W-1:0]       bus_addr = '0;
    logic [63:0]             bus_wdata = '0;
    logic [63:0]             bus_rdata;
    logic                    bus_rvalid;
    logic [N_CAT-1:0]        evt_pulse = '0;
    logic [N_CAT*CODE_W-1:0] evt_code = '0;
    logic [N_CAT*16-1:0]     evt_attr = '0;
    logic                    irq;

    int total = 0;
    int bad   = 0;
    logic last_rvalid;

    always #2 clk = ~clk;

    evt_perf_monitor #(
        .N_CTR(N_CTR), .CTR_W(CTR_W), .N_CAT(N_CAT), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .evt_pulse(evt_pulse), .evt_code(evt_code),
        .evt_attr(evt_attr), .irq(irq)
    );

    function automatic logic [8:0] ca(int idx, int s);
        return 9'((idx + 1) * 64 + s * 8);
    endfunction

    function automatic logic [15:0] mk_attr(int wq, int tc, int pg, int xf, int en);
        return {5'(wq), 3'(tc), 2'(pg), 3'(xf), 3'(en)};
    endfunction

    function automatic logic [63:0] mk_cfg(int en, int ie, int cat, int code);
        return 64'(en) | (64'(ie) << 1) | (64'(cat) << 8) | (64'(code) << 16);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(logic [8:0] a, logic [63:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(logic [8:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        last_rvalid = bus_rvalid;
    endtask

    task automatic fire(int cat, int code, logic [15:0] attr);
        @(negedge clk);
        evt_pulse[cat] = 1'b1;
        evt_code[cat*CODE_W +: CODE_W] = CODE_W'(code);
        evt_attr[cat*16 +: 16] = attr;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    // R1/R10: state right after reset
    task automatic t_reset();
        logic [63:0] d, cap;
        cap = 64'd4 | (64'd48 << 8) | (64'd1 << 16) | (64'd1 << 17)
            | (64'd4 << 20) | (64'hF << 32) | (64'h1F << 48);
        bread(A_CAP, d);  chk("R1 capability", d, cap);
        chk("R10 rvalid after read", 64'(last_rvalid), 64'd1);
        bread(A_OVF, d);  chk("R3 ovf after reset", d, 64'd0);
        bread(ca(0, 0), d); chk("R2 cfg after reset", d, 64'd0);
        chk("R7 irq after reset", 64'(irq), 64'd0);
    endtask

    // R2: category and code selection, enable bit
    task automatic t_count();
        logic [63:0] d;
        bwrite(ca(0, 0), mk_cfg(1, 0, 1, 5));
        bwrite(ca(1, 0), mk_cfg(0, 0, 1, 5));
        bread(ca(0, 0), d); chk("R2 cfg readback", d, mk_cfg(1, 0, 1, 5));
        for (int n = 0; n < 3; n++) fire(1, 5, 16'h0);
        fire(1, 6, 16'h0);
        fire(2, 5, 16'h0);
        bread(ca(0, 1), d); chk("R2 matching events counted", d, 64'd3);
        bread(ca(1, 1), d); chk("R2 disabled counter holds", d, 64'd0);
    endtask

    // R8: mask filters on traffic class and work queue
    task automatic t_filter();
        logic [63:0] d;
        bwrite(ca(1, 0), mk_cfg(1, 0, 0, 7));
        bwrite(ca(1, 3), 64'h04);
        bread(ca(1, 3), d); chk("R8 tc filter readback", d, 64'h04);
        fire(0, 7, mk_attr(0, 2, 0, 0, 0));
        fire(0, 7, mk_attr(0, 2, 1, 5, 6));
        fire(0, 7, mk_attr(0, 3, 0, 0, 0));
        bread(ca(1, 1), d); chk("R8 tc filter gates", d, 64'd2);
        bwrite(ca(1, 2), 64'd1 << 10);
        fire(0, 7, mk_attr(10, 2, 0, 0, 0));
        fire(0, 7, mk_attr(11, 2, 0, 0, 0));
        fire(0, 7, mk_attr(10, 1, 0, 0, 0));
        bread(ca(1, 1), d); chk("R8 all enabled filters must pass", d, 64'd3);
    endtask

    // R5: freeze holds values, unfreeze resumes
    task automatic t_freeze();
        logic [63:0] d;
        bwrite(A_FRZ, 64'd1);
        bread(A_FRZ, d); chk("R5 freeze readback", d, 64'd1);
        fire(1, 5, 16'h0);
        fire(1, 5, 16'h0);
        bread(ca(0, 1), d); chk("R5 frozen counter held", d, 64'd3);
        bwrite(A_FRZ, 64'd0);
        fire(1, 5, 16'h0);
        bread(ca(0, 1), d); chk("R5 counting resumes", d, 64'd4);
    endtask

    // R3/R7/R9: wrap, flag, interrupt, zero extension
    task automatic t_overflow();
        logic [63:0] d;
        bwrite(ca(2, 1), MAXV - 1);
        bwrite(ca(2, 0), mk_cfg(1, 1, 3, 1));
        fire(3, 1, 16'h0);
        bread(ca(2, 1), d); chk("R9 all-ones value zero-extended", d, MAXV);
        bread(A_OVF, d);   chk("R3 no flag before wrap", d, 64'd0);
        fire(3, 1, 16'h0);
        bread(ca(2, 1), d); chk("R3 counter wrapped to zero", d, 64'd0);
        bread(A_OVF, d);   chk("R3 flag set on wrap", d, 64'd4);
        chk("R7 irq on enabled flag", 64'(irq), 64'd1);
        bwrite(ca(3, 1), {64{1'b1}});
        bread(ca(3, 1), d); chk("R9 write truncated to width", d, MAXV);
    endtask

    // R4/R7: write-1-to-clear per bit, interrupt masking
    task automatic t_w1c();
        logic [63:0] d;
        bwrite(ca(3, 0), mk_cfg(1, 0, 3, 1));
        fire(3, 1, 16'h0);
        bread(A_OVF, d); chk("R3 second counter wraps", d, 64'd12);
        bwrite(A_OVF, 64'd0);
        bread(A_OVF, d); chk("R4 writing zero keeps bits", d, 64'd12);
        chk("R7 irq held while flag pending", 64'(irq), 64'd1);
        bwrite(A_OVF, 64'd4);
        bread(A_OVF, d); chk("R4 one bit cleared alone", d, 64'd8);
        chk("R7 unenabled flag raises no irq", 64'(irq), 64'd0);
        bwrite(A_OVF, 64'd8);
        bread(A_OVF, d); chk("R4 last bit cleared", d, 64'd0);
    endtask

    // R9: a data write wins over an event on the same edge
    task automatic t_priority();
        logic [63:0] d;
        @(negedge clk);
        evt_pulse[3] = 1'b1;
        evt_code[3*CODE_W +: CODE_W] = 8'd1;
        evt_attr[3*16 +: 16] = 16'h0;
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = ca(2, 1); bus_wdata = 64'd100;
        @(negedge clk);
        evt_pulse = '0; bus_req = 1'b0; bus_wr = 1'b0;
        bread(ca(2, 1), d); chk("R9 write beats same-cycle event", d, 64'd100);
        fire(3, 1, 16'h0);
        bread(ca(2, 1), d); chk("R9 counting after load", d, 64'd101);
    endtask

    // R6: counter reset and configuration reset commands
    task automatic t_cmd();
        logic [63:0] d;
        bwrite(A_CMD, 64'd2);
        bread(ca(0, 1), d); chk("R6 counter reset zeroes data", d, 64'd0);
        bread(ca(2, 1), d); chk("R6 counter reset zeroes data 2", d, 64'd0);
        bread(ca(0, 0), d); chk("R6 counter reset keeps cfg", d, mk_cfg(1, 0, 1, 5));
        bwrite(ca(2, 1), MAXV);
        fire(3, 1, 16'h0);
        bwrite(A_FRZ, 64'd1);
        chk("R7 irq before config reset", 64'(irq), 64'd1);
        bwrite(A_CMD, 64'd1);
        bread(A_OVF, d);   chk("R6 config reset clears status", d, 64'd0);
        bread(A_FRZ, d);   chk("R6 config reset unfreezes", d, 64'd0);
        bread(ca(0, 0), d); chk("R6 config reset clears cfg", d, 64'd0);
        bread(ca(1, 3), d); chk("R6 config reset clears filter", d, 64'd0);
        bread(ca(3, 1), d); chk("R6 config reset keeps data", d, 64'd1);
        bread(A_CMD, d);   chk("R6 command reads zero", d, 64'd0);
        chk("R7 irq low after config reset", 64'(irq), 64'd0);
    endtask

    // R10: unused and misaligned addresses read as zero
    task automatic t_unmapped();
        logic [63:0] d;
        bread(9'h020, d);     chk("R10 unused global slot", d, 64'd0);
        chk("R10 rvalid on unused read", 64'(last_rvalid), 64'd1);
        bread(ca(0, 7), d);   chk("R10 unused counter slot", d, 64'd0);
        bread(9'h001, d);     chk("R10 misaligned read", d, 64'd0);
        @(negedge clk);
        chk("R10 rvalid drops when idle", 64'(bus_rvalid), 64'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_filter();
        t_freeze();
        t_overflow();
        t_w1c();
        t_priority();
        t_cmd();
        t_unmapped();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule